// File: doc/BRIEF.md
# Edge-Interrupt Fixed-Direction Pin Controller

This block sits on a narrow byte-wide register bus and looks after eight pins whose roles never change. The lower four pins are driven from output latches. The upper four pins are sampled as inputs. Each input can raise an event on a rising edge, a falling edge or both. Events are held in sticky status bits, and the block drives one shared interrupt line.

Software programs an edge mode for each input. When the interrupt line rises, software reads the status byte and writes the same value back. Only the events it has seen are cleared, so an event that arrives later is never lost. Every input passes through a two-stage synchroniser before edge detection. Reads return data on the clock after the read request.

Top module: `pinbank_edge_irq`

## Requirements
- R1: After a synchronous reset, the output pins are 0 and the interrupt line is 0. The edge configuration register and the status register both read back as 0.
- R2: Offset 0 always reads 0x0F, where a 1 marks an output pin. A write to offset 0 changes neither that value nor the output pins.
- R3: A write to offset 1 loads write-data bits [3:0] onto output pins [3:0]. Bits [7:4] of that write are ignored. No other access changes the output pins.
- R4: A read of offset 1 returns the synchronised input levels in bits [7:4] and the output latch values in bits [3:0].
- R5: Offset 3 is a read/write edge configuration byte. Bits [2n+1:2n] hold the mode of input n, where input n is pin 4+n.
- R6: When bit 1 of a pair is set, a rising edge on that input sets status bit n. A falling edge sets no status bit unless bit 0 of the pair is also set.
- R7: When bit 0 of a pair is set, a falling edge on that input sets status bit n.
- R8: Pair value 11 detects both edges. Pair value 00 masks the input, so no edge on it sets a status bit.
- R9: Offset 4 reads the status bits in [3:0] and reads 0 in [7:4]. Writing a 1 to a status bit clears it. Writing a 0 leaves the bit unchanged.
- R10: If an edge is detected on the same clock as a write that clears its status bit, the bit stays set.
- R11: The interrupt output is high exactly while at least one status bit is set.
- R12: Reads of offsets 2, 5, 6 and 7 return 0.
- R13: After an input changes, the matching status bit and the interrupt line change on the third rising clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe. Data appears on the next clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data. It is 0 when no read took place |
| out_pins | output | 4 | Output latch values for pins 0 to 3 |
| in_pins | input | 4 | Asynchronous input pins 4 to 7 |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach is a status clear that lands on the same clock edge on which a new edge is detected for that bit. The input is changed on a falling clock edge. The bench then counts two rising edges, which covers the synchroniser depth, and issues the clear write so that it is sampled on the third edge, the one on which the event is detected. Partial clears and masked inputs are exercised while other status bits are pending. These tests show that only the written bits are cleared and that the interrupt line stays high.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int OFF_DIR  = 0;
  localparam int OFF_DATA = 1;
  localparam int OFF_CFG  = 3;
  localparam int OFF_STAT = 4;
  localparam int MODE_W   = 2;
  localparam int MODE_FALL_BIT = 0;
  localparam int MODE_RISE_BIT = 1;
endpackage

// File: rtl/pb_edge_detect.sv
module pb_edge_detect
  import pinbank_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        pins_async,
  input  logic [MODE_W*NUM_IN-1:0] mode,
  output logic [NUM_IN-1:0]        level,
  output logic [NUM_IN-1:0]        evt
);
  logic [NUM_IN-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pins_async;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign level = stage2_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    logic rise, fall;
    assign rise   = stage2_q[i] & ~prev_q[i];
    assign fall   = ~stage2_q[i] & prev_q[i];
    assign evt[i] = (rise & mode[MODE_W*i + MODE_RISE_BIT]) |
                    (fall & mode[MODE_W*i + MODE_FALL_BIT]);
  end
endmodule

// File: rtl/pb_event_status.sv
module pb_event_status #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] evt,
  input  logic [NUM_IN-1:0] clr_mask,
  output logic [NUM_IN-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_mask) | evt;
  end

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(clr_mask & ~evt)) == '0));

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/pinbank_edge_irq.sv
module pinbank_edge_irq
  import pinbank_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_OUT-1:0] out_pins,
  input  logic [NUM_IN-1:0] in_pins,
  output logic              irq
);
  localparam int CFG_W = MODE_W * NUM_IN;
  localparam logic [DATA_W-1:0] DIR_VAL = DATA_W'((1 << NUM_OUT) - 1);

  logic [NUM_OUT-1:0] out_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_IN-1:0]  level, evt, status_q, clr_mask;
  logic [DATA_W-1:0]  rd_mux;

  logic hit_data, hit_cfg, hit_stat;
  assign hit_data = bus_addr == ADDR_W'(OFF_DATA);
  assign hit_cfg  = bus_addr == ADDR_W'(OFF_CFG);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      cfg_q <= '0;
    end else if (bus_wr) begin
      if (hit_data) out_q <= bus_wdata[NUM_OUT-1:0];
      if (hit_cfg)  cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  assign clr_mask = (bus_wr && hit_stat) ? bus_wdata[NUM_IN-1:0] : '0;

  pb_edge_detect #(.NUM_IN(NUM_IN)) u_edge (
    .clk(clk), .rst(rst), .pins_async(in_pins), .mode(cfg_q),
    .level(level), .evt(evt)
  );

  pb_event_status #(.NUM_IN(NUM_IN)) u_stat (
    .clk(clk), .rst(rst), .evt(evt), .clr_mask(clr_mask),
    .status_q(status_q)
  );

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      OFF_DIR:  rd_mux = DIR_VAL;
      OFF_DATA: rd_mux = DATA_W'({level, out_q});
      OFF_CFG:  rd_mux = DATA_W'(cfg_q);
      OFF_STAT: rd_mux = DATA_W'(status_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign out_pins = out_q;
  assign irq      = |status_q;

  assert_dir_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_DIR)) |=> (bus_rdata == DIR_VAL));

  assert_out_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && hit_data) |=> $stable(out_pins));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(evt != '0));
endmodule

// File: tb/pinbank_edge_irq_test.sv
module pinbank_edge_irq_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] out_pins;
  logic [3:0] in_pins = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pinbank_edge_irq uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_pins(out_pins), .in_pins(in_pins), .irq(irq)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 8'h0F},  // R2
    {1'b1, 3'd0, 8'hFF, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h0F},  // R2 after write
    {1'b0, 3'd1, 8'h00, 8'h00},  // R4
    {1'b1, 3'd1, 8'hA5, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h05},  // R3 upper bits dropped
    {1'b1, 3'd3, 8'hC6, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'hC6},  // R5
    {1'b0, 3'd2, 8'h00, 8'h00},  // R12
    {1'b0, 3'd5, 8'h00, 8'h00},  // R12
    {1'b0, 3'd6, 8'h00, 8'h00},  // R12
    {1'b0, 3'd7, 8'h00, 8'h00},  // R12
    {1'b0, 3'd4, 8'h00, 8'h00}   // R9
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(logic wr, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = ~wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    bus_op(1'b0, a, 8'h00);
    check(req, bus_rdata, exp);
  endtask

  task automatic pin_set(logic [3:0] v);
    @(negedge clk);
    in_pins = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out", {4'b0, out_pins}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    @(negedge clk) rst = 1'b0;
    rd_check("R1 cfg", 3'd3, 8'h00);
    rd_check("R1 status", 3'd4, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      if (!VEC[i][19]) check($sformatf("R2-5/R12 vec%0d", i), bus_rdata, VEC[i][7:0]);
    end
    check("R3 pins", {4'b0, out_pins}, 8'h05);

    // modes: in0 rise, in1 fall, in2 both, in3 masked
    bus_op(1'b1, 3'd3, 8'b00_11_01_10);

    // R13 latency on in0 rise
    @(negedge clk) in_pins = 4'b0001;
    repeat (2) @(posedge clk);
    #1 check("R13 not early", {7'b0, irq}, 8'h00);
    @(posedge clk);
    #1 check("R13 third edge", {7'b0, irq}, 8'h01);
    rd_check("R6 rise", 3'd4, 8'h01);
    bus_op(1'b1, 3'd4, 8'h01);
    rd_check("R9 cleared", 3'd4, 8'h00);
    check("R11 low", {7'b0, irq}, 8'h00);
    pin_set(4'b0000);
    rd_check("R6 fall ignored", 3'd4, 8'h00);

    pin_set(4'b0010);
    rd_check("R7 rise ignored", 3'd4, 8'h00);
    pin_set(4'b0000);
    rd_check("R7 fall", 3'd4, 8'h02);

    pin_set(4'b0100);
    rd_check("R8 both rise", 3'd4, 8'h06);
    bus_op(1'b1, 3'd4, 8'h04);
    rd_check("R9 partial clear", 3'd4, 8'h02);
    check("R11 still high", {7'b0, irq}, 8'h01);
    bus_op(1'b1, 3'd4, 8'hF2);
    rd_check("R9 clear all", 3'd4, 8'h00);
    pin_set(4'b0000);
    rd_check("R8 both fall", 3'd4, 8'h04);
    bus_op(1'b1, 3'd4, 8'h04);

    pin_set(4'b1000);
    pin_set(4'b0000);
    rd_check("R8 masked", 3'd4, 8'h00);
    check("R8 masked irq", {7'b0, irq}, 8'h00);

    // R10: clear lands on the same edge the in2 event is detected
    pin_set(4'b0100);
    rd_check("R10 setup", 3'd4, 8'h04);
    @(negedge clk) in_pins = 4'b0000;
    repeat (2) @(posedge clk);
    bus_op(1'b1, 3'd4, 8'h04);
    rd_check("R10 event wins", 3'd4, 8'h04);
    bus_op(1'b1, 3'd4, 8'h04);
    rd_check("R10 later clear", 3'd4, 8'h00);

    pin_set(4'b1010);
    rd_check("R4 input levels", 3'd1, 8'hA5);
    bus_op(1'b1, 3'd1, 8'h0C);
    check("R3 new pins", {4'b0, out_pins}, 8'h0C);

    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset pins", {4'b0, out_pins}, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    finish_up();
  end
endmodule